// File: doc/BRIEF.md
# Register Bank Slave on a Two-Wire Serial Bus

This block gives a host access to seven 8-bit configuration and status registers over a Fast-mode I2C bus, acting only as a slave. The system clock samples SCL and SDA. The block never drives either line high. It drives SDA low through a drive-enable output, and the board resistor pulls the line up.

Each device answers its own 7-bit address. The upper five bits of that address are fixed and two strap pins select the lower two bits. Every device also accepts a shared broadcast write address, so one write transaction can reconfigure several devices together.

The first byte after the address byte loads a register pointer. Each data byte after that is written to the register the pointer selects, and the pointer then advances.

A read starts with a write that sets the pointer, followed by a repeated start and the address with the read bit set. The block then returns bytes from successive registers until the host answers a byte with NACK.

The status register collects fault flags from the protection logic. These flags stay set until software clears them by writing 1 to them. The identity register holds a fixed chip code and a live temperature code.

Top module: `regbank_i2c_slave`

## Requirements
- R1: An address byte with the upper seven bits equal to `{01100, strap[1], strap[0]}` is acknowledged. A write to any other device address is not acknowledged and leaves every register unchanged.
- R2: The address byte 68h (7-bit address 34h with the write bit) is acknowledged by every device, and the write takes effect. The byte 69h (the same address with the read bit) is not acknowledged.
- R3: The byte after a write address loads the register pointer. Each data byte after it is acknowledged, written to the selected register, and advances the pointer by one. The configuration outputs change only when a data byte is written.
- R4: A read consists of a pointer write, a repeated start, and the device address with the read bit set. The block returns the selected register and advances the pointer after each byte. When the host NACKs a byte, the block releases SDA and serves the next transaction normally.
- R5: After reset the registers read 00h, 00h, 87h, 00h, {01000b, temp}, 80h and 02h, at pointer values 0 to 6 in that order.
- R6: Reserved bits always read 0 and ignore writes. The writable masks are 3Fh for register 1, AFh for register 2 and EFh for register 6. Registers 0 and 5 are fully writable.
- R7: Register 4 is read-only. Bits 7..3 read 01000b and bits 2..0 follow the temperature input. A write to register 4 is acknowledged and has no effect.
- R8: Status register 3 sets bit n in the cycle after fault input n is high. The bit then stays set until a write to register 3 carries a 1 in that bit, and a write of FFh clears all eight bits. Bit 7 is overcurrent, bits 6..4 are short on strings 3..1, bits 3..1 are overvoltage on strings 3..1, and bit 0 is overtemperature.
- R9: When a fault input sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R10: When the pointer advances past 6 it wraps to 0. A pointer byte greater than 6 selects register 0.
- R11: The block asserts its SDA drive only while the sampled SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | SCL pull-low enable (the block never stretches the clock, so this is always 0) |
| sdaOe | output | 1 | SDA pull-low enable |
| strap | input | 2 | Address strap pins, the two low bits of the device address |
| tempCode | input | 3 | Temperature code, shown in register 4 bits 2..0 |
| faultSet | input | 8 | Fault set pulses, one per status bit |
| dutyCode | output | 14 | Dimming duty code, {reg0, reg1[5:0]} |
| ctrlReg | output | 8 | Control register 2 |
| statusReg | output | 8 | Sticky status register 3 |
| divLsb | output | 8 | Divider fraction register 5 |
| divCfg | output | 8 | Divider integer and mode register 6 |

## Verification
The bench sends addresses that match the strap, addresses that do not match, and the broadcast address with each direction bit. This separates a correct address decoder from one that acknowledges too much or too little. All-ones data separates masked bits from writable ones. Bursts that cross pointer 6, and a pointer byte above 6, expose faults in the wrap logic.

Faults are applied in two ways: as short pulses, and held across a clearing write. This tells sticky storage apart from live tracking, and it checks that a set wins over a clear in the same cycle. A reference model in the bench is compared with the register outputs on every clock.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int NREG    = 7;
  localparam int PTR_W   = $clog2(NREG);
  localparam int SLOTS   = 2 ** PTR_W;
  localparam int STAT_IDX = 3;
  localparam int ID_IDX   = 4;
  localparam int TEMP_W   = 3;
  localparam int ID_W     = 8 - TEMP_W;

  typedef logic [SLOTS-1:0][7:0] regArr_t;

  typedef struct packed {
    logic       setPtr;
    logic       wrEn;
    logic       rdAdv;
    logic [7:0] data;
  } busStb_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_SUB, ST_WDATA, ST_ACK, ST_TX, ST_TXACK, ST_WAIT
  } busSt_t;

  function automatic logic [7:0] regMask(input int idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'h3F;
      2:       return 8'hAF;
      5:       return 8'hFF;
      6:       return 8'hEF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] regReset(input int idx);
    case (idx)
      2:       return 8'h87;
      5:       return 8'h80;
      6:       return 8'h02;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2cBusCtrl.sv
module i2cBusCtrl
  import regbank_pkg::*;
#(
  parameter logic [4:0] ADDR_HI    = 5'b01100,
  parameter logic [6:0] BCAST_ADDR = 7'h34
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] strap,
  input  logic [7:0] rdData,
  output logic       sdaOe,
  output logic       sclLvl,
  output busStb_t    stb
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(8);

  logic sclMeta, sclS, sclD, sdaMeta, sdaS, sdaD;
  logic sclRise, sclFall, startEv, stopEv, byteDone;
  logic devHit, bcHit, loadTx;
  busSt_t state, nextSt;
  logic [CNT_W-1:0] bitCnt;
  logic [7:0] shiftQ;

  // two-stage synchronisers plus one delay stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {sclMeta, sclS, sclD} <= 3'b111;
      {sdaMeta, sdaS, sdaD} <= 3'b111;
    end else begin
      {sclMeta, sclS, sclD} <= {sclIn, sclMeta, sclS};
      {sdaMeta, sdaS, sdaD} <= {sdaIn, sdaMeta, sdaS};
    end
  end

  assign sclLvl  = sclS;
  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startEv = sclS & sclD & sdaD & ~sdaS;
  assign stopEv  = sclS & sclD & ~sdaD & sdaS;

  always_comb begin
    byteDone   = sclFall && (bitCnt == FULL);
    devHit     = shiftQ[7:1] == {ADDR_HI, strap};
    bcHit      = shiftQ == {BCAST_ADDR, 1'b0};
    loadTx     = sclFall && ((state == ST_ACK && nextSt == ST_TX) || state == ST_TXACK);
    stb.setPtr = (state == ST_SUB) && byteDone;
    stb.wrEn   = (state == ST_WDATA) && byteDone;
    stb.rdAdv  = loadTx;
    stb.data   = shiftQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      nextSt <= ST_IDLE;
      bitCnt <= '0;
      shiftQ <= '0;
      sdaOe  <= 1'b0;
    end else if (startEv) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (stopEv) begin
      state <= ST_IDLE;
      sdaOe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_WDATA: begin
          if (sclRise && bitCnt != FULL) begin
            shiftQ <= {shiftQ[6:0], sdaS};
            bitCnt <= bitCnt + 1'b1;
          end else if (byteDone) begin
            if (state != ST_ADDR || devHit || bcHit) begin
              sdaOe <= 1'b1;
              state <= ST_ACK;
              if (state == ST_ADDR) nextSt <= shiftQ[0] ? ST_TX : ST_SUB;
              else                  nextSt <= ST_WDATA;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            state  <= nextSt;
            if (loadTx) begin
              shiftQ <= rdData;
              sdaOe  <= ~rdData[7];
            end else begin
              sdaOe <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == FULL) begin
              sdaOe  <= 1'b0;
              bitCnt <= '0;
              state  <= ST_TXACK;
            end else begin
              shiftQ <= {shiftQ[6:0], 1'b0};
              sdaOe  <= ~shiftQ[6];
            end
          end
        end
        ST_TXACK: begin
          if (sclRise && sdaS) begin
            state <= ST_WAIT;
          end else if (sclFall) begin
            shiftQ <= rdData;
            sdaOe  <= ~rdData[7];
            bitCnt <= '0;
            state  <= ST_TX;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/regBankPath.sv
module regBankPath
  import regbank_pkg::*;
#(
  parameter logic [ID_W-1:0] CHIP_ID = 5'b01000
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStb_t           stb,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [7:0]        faultSet,
  output logic [7:0]        rdData,
  output logic [PTR_W-1:0]  ptrQ,
  output regArr_t           regView
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NREG - 1);

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ptrQ <= '0;
    else if (stb.setPtr)       ptrQ <= (stb.data < 8'(NREG)) ? stb.data[PTR_W-1:0] : '0;
    else if (stb.wrEn || stb.rdAdv) ptrQ <= ptrInc(ptrQ);
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i == STAT_IDX) begin : g_stat
      logic [7:0] q;
      logic [7:0] clrMask;
      assign clrMask = (stb.wrEn && ptrQ == PTR_W'(i)) ? stb.data : 8'h00;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= 8'h00;
        else       q <= (q & ~clrMask) | faultSet;  // set wins over clear
      end
      assign regView[i] = q;
    end else if (i == ID_IDX) begin : g_id
      assign regView[i] = {CHIP_ID, tempCode};
    end else if (i < NREG) begin : g_cfg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= regReset(i);
        else if (stb.wrEn && ptrQ == PTR_W'(i)) q <= stb.data & regMask(i);
      end
      assign regView[i] = q;
    end else begin : g_none
      assign regView[i] = 8'h00;
    end
  end

  assign rdData = regView[ptrQ];
endmodule

// File: rtl/regbank_i2c_slave.sv
module regbank_i2c_slave
  import regbank_pkg::*;
#(
  parameter logic [4:0]      ADDR_HI    = 5'b01100,
  parameter logic [6:0]      BCAST_ADDR = 7'h34,
  parameter logic [ID_W-1:0] CHIP_ID    = 5'b01000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic [1:0]        strap,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [7:0]        faultSet,
  output logic [13:0]       dutyCode,
  output logic [7:0]        ctrlReg,
  output logic [7:0]        statusReg,
  output logic [7:0]        divLsb,
  output logic [7:0]        divCfg
);
  busStb_t          stb;
  logic [7:0]       rdData;
  logic [PTR_W-1:0] ptrQ;
  logic             sclLvl;
  regArr_t          regView;

  i2cBusCtrl #(.ADDR_HI(ADDR_HI), .BCAST_ADDR(BCAST_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strap(strap),
    .rdData(rdData), .sdaOe(sdaOe), .sclLvl(sclLvl), .stb(stb)
  );

  regBankPath #(.CHIP_ID(CHIP_ID)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .tempCode(tempCode), .faultSet(faultSet),
    .rdData(rdData), .ptrQ(ptrQ), .regView(regView)
  );

  assign sclOe     = 1'b0;
  assign dutyCode  = {regView[0], regView[1][5:0]};
  assign ctrlReg   = regView[2];
  assign statusReg = regView[STAT_IDX];
  assign divLsb    = regView[5];
  assign divCfg    = regView[6];
endmodule

// File: rtl/regbank_i2c_checker.sv
module regbank_i2c_checker
  import regbank_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             sclLvl,
  input logic             sdaOe,
  input busStb_t          stb,
  input logic [PTR_W-1:0] ptrQ,
  input logic [7:0]       faultSet,
  input logic [7:0]       statusReg,
  input logic [13:0]      dutyCode,
  input logic [7:0]       ctrlReg,
  input logic [7:0]       divLsb,
  input logic [7:0]       divCfg
);
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclLvl);  // R11

  AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (|faultSet) |=> ((statusReg & $past(faultSet)) == $past(faultSet)));  // R9

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrEn && ptrQ == PTR_W'(STAT_IDX)) |=> ((statusReg & $past(statusReg)) == $past(statusReg)));  // R8

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrEn |=> ($stable(dutyCode) && $stable(ctrlReg) && $stable(divLsb) && $stable(divCfg)));  // R3

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ptrQ < PTR_W'(NREG));  // R10
endmodule

bind regbank_i2c_slave regbank_i2c_checker u_chk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sdaOe(sdaOe), .stb(stb), .ptrQ(ptrQ),
  .faultSet(faultSet), .statusReg(statusReg), .dutyCode(dutyCode), .ctrlReg(ctrlReg),
  .divLsb(divLsb), .divCfg(divCfg)
);

// File: tb/test_regbank_i2c_slave.sv
`timescale 1ns/1ps
module test_regbank_i2c_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic [1:0] strap = 2'b10;
  logic [2:0] tempCode = 3'd5;
  logic [7:0] faultSet = 8'h00;
  logic sclOe, sdaOe;
  logic [13:0] dutyCode;
  logic [7:0] ctrlReg, statusReg, divLsb, divCfg;
  wire sdaLine = sdaDrv & ~sdaOe;

  int testCnt = 0, failCnt = 0, r11Bad = 0;
  bit done = 0, modelValid = 0, prevOe = 0;
  logic [7:0] mdl [7];
  logic [7:0] statModel = 8'h00, clrReq = 8'h00;
  int clrSeq = 0, seenSeq = 0;

  always #2 clk = ~clk;

  regbank_i2c_slave i_regbank_i2c_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe),
    .strap(strap), .tempCode(tempCode), .faultSet(faultSet), .dutyCode(dutyCode),
    .ctrlReg(ctrlReg), .statusReg(statusReg), .divLsb(divLsb), .divCfg(divCfg)
  );

  function automatic logic [7:0] bmask(input int p);
    case (p) 0, 5: return 8'hFF; 1: return 8'h3F; 2: return 8'hAF; 6: return 8'hEF; default: return 8'h00; endcase
  endfunction

  function automatic logic [7:0] expRead(input int p);
    if (p == 3) return statModel;
    if (p == 4) return {5'b01000, tempCode};
    return mdl[p];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // status model: sticky, W1C, set wins (R8, R9)
  always @(posedge clk) begin
    if (!rstN) statModel <= 8'h00;
    else if (clrSeq != seenSeq) begin
      statModel <= (statModel & ~clrReq) | faultSet;
      seenSeq   <= clrSeq;
    end else statModel <= statModel | faultSet;
  end

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (rstN && modelValid) begin
      chk(dutyCode == {mdl[0], mdl[1][5:0]}, "R3 duty", dutyCode, {mdl[0], mdl[1][5:0]});
      chk(ctrlReg == mdl[2], "R3 ctrl", ctrlReg, mdl[2]);
      chk(divLsb == mdl[5], "R3 divLsb", divLsb, mdl[5]);
      chk(divCfg == mdl[6], "R3 divCfg", divCfg, mdl[6]);
      chk(statusReg == statModel, "R8 status", statusReg, statModel);
    end
    if (sdaOe && !prevOe && sclDrv) r11Bad++;
    prevOe = sdaOe;
  end

  task automatic qw(input int n = 1); repeat (n * Q) @(negedge clk); endtask

  task automatic startCond();
    sdaDrv = 1; sclDrv = 1; qw(); sdaDrv = 0; qw(); sclDrv = 0; qw();
  endtask
  task automatic repStart();
    sdaDrv = 1; qw(); sclDrv = 1; qw(); sdaDrv = 0; qw(); sclDrv = 0; qw();
  endtask
  task automatic stopCond();
    sdaDrv = 0; qw(); sclDrv = 1; qw(); sdaDrv = 1; qw(2);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = b[i]; qw(); sclDrv = 1; qw(2); sclDrv = 0; qw();
    end
    sdaDrv = 1; qw(); sclDrv = 1; qw(); ack = ~sdaLine; qw(); sclDrv = 0; qw();
  endtask

  task automatic readByte(input bit ackIt, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      qw(); sclDrv = 1; qw(); b[i] = sdaLine; qw(); sclDrv = 0;
    end
    qw(); sdaDrv = ackIt ? 1'b0 : 1'b1; qw(); sclDrv = 1; qw(2); sclDrv = 0; qw(); sdaDrv = 1;
  endtask

  task automatic writeRegs(input logic [6:0] a, input logic [7:0] sub, input logic [7:0] d[$],
                           input bit expAck, input string req);
    bit ak;
    int p;
    modelValid = 0;
    startCond();
    sendByte({a, 1'b0}, ak);
    chk(ak == expAck, req, ak, expAck);
    if (ak) begin
      sendByte(sub, ak);
      p = (sub < 7) ? int'(sub) : 0;
      foreach (d[k]) begin
        sendByte(d[k], ak);
        chk(ak, "R3 data ack", ak, 1);
        if (p == 3) begin clrReq = d[k]; clrSeq++; end
        else if (p != 4) mdl[p] = d[k] & bmask(p);
        p = (p + 1) % 7;
      end
    end
    stopCond();
    qw();
    modelValid = 1;
  endtask

  task automatic readRegs(input logic [6:0] a, input logic [7:0] sub, input int n, input string req);
    bit ak;
    logic [7:0] b;
    int p;
    startCond();
    sendByte({a, 1'b0}, ak);
    sendByte(sub, ak);
    repStart();
    sendByte({a, 1'b1}, ak);
    chk(ak, "R4 read address ack", ak, 1);
    p = (sub < 7) ? int'(sub) : 0;
    for (int k = 0; k < n; k++) begin
      readByte(k < n - 1, b);
      chk(b == expRead(p), req, b, expRead(p));
      p = (p + 1) % 7;
    end
    stopCond();
    chk(sdaOe == 1'b0, "R4 SDA released after NACK", sdaOe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testCnt++; failCnt++;
      $display("FAIL R4 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [7:0] wq[$];
    bit ak;
    mdl = '{8'h00, 8'h00, 8'h87, 8'h00, 8'h00, 8'h80, 8'h02};
    repeat (10) @(negedge clk);
    rstN = 1;
    repeat (5) @(negedge clk);
    // R5 reset state at the ports
    chk(dutyCode == 14'h0, "R5 duty reset", dutyCode, 0);
    chk(ctrlReg == 8'h87, "R5 ctrl reset", ctrlReg, 8'h87);
    chk(statusReg == 8'h00, "R5 status reset", statusReg, 0);
    chk(divLsb == 8'h80, "R5 divLsb reset", divLsb, 8'h80);
    chk(divCfg == 8'h02, "R5 divCfg reset", divCfg, 8'h02);
    chk(sdaOe == 1'b0 && sclOe == 1'b0, "R5 bus released", {sclOe, sdaOe}, 0);
    modelValid = 1;
    readRegs(7'h32, 8'h00, 7, "R5 reset readback");

    // R1 strap-selected address, R3 burst write
    wq = {8'hA5, 8'h3C};
    writeRegs(7'h32, 8'h00, wq, 1, "R1 own address ack");
    chk(dutyCode == {8'hA5, 6'h3C}, "R3 burst duty", dutyCode, {8'hA5, 6'h3C});
    wq = {8'h11};
    writeRegs(7'h31, 8'h00, wq, 0, "R1 foreign address nack");
    chk(dutyCode == {8'hA5, 6'h3C}, "R1 foreign write ignored", dutyCode, {8'hA5, 6'h3C});

    // R2 broadcast write and rejected broadcast read
    wq = {8'h11, 8'h6A};
    writeRegs(7'h34, 8'h05, wq, 1, "R2 broadcast ack");
    chk(divLsb == 8'h11, "R2 broadcast applied", divLsb, 8'h11);
    chk(divCfg == 8'h6A, "R3 pointer advance", divCfg, 8'h6A);
    startCond();
    sendByte(8'h69, ak);
    chk(!ak, "R2 broadcast read nack", ak, 0);
    stopCond();

    // R6 reserved bits
    wq = {8'hFF, 8'hFF};
    writeRegs(7'h32, 8'h01, wq, 1, "R6 address ack");
    chk(dutyCode[5:0] == 6'h3F, "R6 reg1 mask", dutyCode[5:0], 6'h3F);
    chk(ctrlReg == 8'hAF, "R6 reg2 mask", ctrlReg, 8'hAF);
    wq = {8'hFF};
    writeRegs(7'h32, 8'h06, wq, 1, "R6 address ack");
    chk(divCfg == 8'hEF, "R6 reg6 mask", divCfg, 8'hEF);
    readRegs(7'h32, 8'h01, 2, "R6 masked readback");

    // R7 read-only identity register
    wq = {8'hFF};
    writeRegs(7'h32, 8'h04, wq, 1, "R7 write ack");
    readRegs(7'h32, 8'h04, 1, "R7 id and temp");
    tempCode = 3'd2;
    readRegs(7'h32, 8'h04, 1, "R7 temp follows input");

    // R8 sticky status with write-one-to-clear
    @(negedge clk); faultSet = 8'h41; @(negedge clk); faultSet = 8'h00;
    qw();
    chk(statusReg == 8'h41, "R8 sticky after pulse", statusReg, 8'h41);
    wq = {8'h01};
    writeRegs(7'h32, 8'h03, wq, 1, "R8 address ack");
    chk(statusReg == 8'h40, "R8 partial clear", statusReg, 8'h40);
    wq = {8'hFF};
    writeRegs(7'h32, 8'h03, wq, 1, "R8 address ack");
    chk(statusReg == 8'h00, "R8 clear all", statusReg, 8'h00);

    // R9 set wins over clear
    @(negedge clk); faultSet = 8'h04;
    qw();
    writeRegs(7'h32, 8'h03, wq, 1, "R9 address ack");
    chk(statusReg == 8'h04, "R9 set beats clear", statusReg, 8'h04);
    @(negedge clk); faultSet = 8'h00;
    writeRegs(7'h32, 8'h03, wq, 1, "R8 address ack");
    chk(statusReg == 8'h00, "R8 clear after fault gone", statusReg, 8'h00);

    // R10 pointer wrap and out-of-range pointer
    wq = {8'h22, 8'h33, 8'h44};
    writeRegs(7'h32, 8'h05, wq, 1, "R10 address ack");
    chk(dutyCode[13:6] == 8'h44, "R10 write wrap to reg0", dutyCode[13:6], 8'h44);
    chk(divCfg == 8'h23, "R10 reg6 before wrap", divCfg, 8'h23);
    readRegs(7'h32, 8'h06, 2, "R10 read wrap");
    wq = {8'h5A};
    writeRegs(7'h32, 8'h0A, wq, 1, "R10 address ack");
    chk(dutyCode[13:6] == 8'h5A, "R10 large pointer selects reg0", dutyCode[13:6], 8'h5A);

    // R4 burst read across all registers after NACK recovery
    readRegs(7'h32, 8'h00, 7, "R4 burst read");
    chk(r11Bad == 0, "R11 drive only with SCL low", r11Bad, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule